// File: doc/BRIEF.md
# Multi-Channel Wide-Word UART FIFO Access Port

This block sits between a 32-bit host bus and the receive and transmit FIFOs of a bank of UART channels. One bus access moves several FIFO bytes at once. A bulk read pops up to four received bytes. A status read pops up to two received bytes, each returned next to its own line-status byte. A bulk write pushes up to four bytes for transmission. The FIFOs are part of the block. A receive-side load port fills the RX FIFOs, and a drain port empties the TX FIFOs. Together these two ports stand in for the serial engines, which this block does not contain.

The block takes the channel from the upper address bits and the window from the 10-bit offset inside that channel. It packs or unpacks the bytes and issues all pops and pushes for the access on a single clock edge. Read data is registered and appears one cycle after the access.

Top module: `uart_wide_port`

## Requirements
- R1: The channel is busAddr[12:10], so each channel owns 0x400 bytes. The window is busAddr[9:0]: 0x100 is the bulk window (read pops RX, write pushes TX) and 0x200 is the read-only status window.
- R2: A bulk read with all byte enables set returns the oldest RX byte in bits 7:0, the next in 15:8, then 23:16, and the newest in 31:24. It pops those four entries.
- R3: A status read with all enables set returns status n in bits 7:0, data n in 15:8, status n+1 in 23:16 and data n+1 in 31:24, and pops two entries. The status byte is returned exactly as loaded: bit 0 ready, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break.
- R4: A 16-bit status read (enables 0011) pops exactly one entry, with its status in bits 7:0 and its data in bits 15:8.
- R5: A bulk write with all enables set pushes bits 7:0 first, then 15:8, 23:16 and 31:24. The drain port shows the oldest TX byte on txPeekData.
- R6: Byte enables pick the lanes. Successive FIFO entries fill or come from the enabled lanes in ascending order. In the status window, a lane pair (bytes 1:0 or 3:2) counts only when both of its enables are set.
- R7: When a read asks for more entries than the RX FIFO holds, the lanes that get no entry read zero, and no pop is made for them.
- R8: Bytes of a write that do not fit in the TX FIFO are dropped. The channel's bit in txOverflow then sets and stays set until reset.
- R9: busRdata is registered: it shows the read result in the cycle after the access and is zero after any cycle without a read. It is zero in reset.
- R10: Any other offset, and a write to offset 0x200, reads zero and changes no FIFO.
- R11: rxLoadValid appends {rxLoadStatus, rxLoadData} to channel rxLoadCh, and the byte is dropped if that FIFO is full. txTake pops the head of channel txPeekCh if it is not empty. txPeekCount gives that channel's fill level, and txPeekData is zero when it is empty. Fullness and emptiness are judged on the level before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 13 | Byte address: channel and offset |
| busByteEn | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rxLoadValid | input | 1 | Append one received entry |
| rxLoadCh | input | 3 | Channel for the received entry |
| rxLoadData | input | 8 | Received data byte |
| rxLoadStatus | input | 8 | Line-status byte for that data |
| txPeekCh | input | 3 | Channel shown on the drain port |
| txTake | input | 1 | Pop the head of the selected TX FIFO |
| txPeekData | output | 8 | Oldest TX byte of the selected channel |
| txPeekCount | output | 4 | TX fill level of the selected channel |
| txOverflow | output | 8 | Sticky per-channel TX overflow flags |

## Verification
The assertions check, on every cycle, that no FIFO is asked for more pops than it holds and never exceeds its depth. They also check that an access never pops and pushes at once, that overflow flags never clear, and that read data falls back to zero after idle cycles. Only the bench scenarios can show that byte order, the pairing of status with data, lane selection under partial enables, and the effect of ignored offsets are correct. They show this by comparing the ports against a queue model on every clock.

// File: rtl/uwp_pkg.sv
package uwp_pkg;
  localparam int LANES = 4;
  localparam logic [9:0] OFF_BULK = 10'h100;
  localparam logic [9:0] OFF_STAT = 10'h200;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_RXBULK,
    WIN_RXSTAT,
    WIN_TXBULK
  } win_e;

  // Strobes from control to datapath. slotMask is per lane (bulk) or per pair (status).
  typedef struct packed {
    win_e             win;
    logic [LANES-1:0] slotMask;
    logic [2:0]       popN;
    logic [2:0]       pushN;
  } strobe_t;
endpackage

// File: rtl/uwp_fifo.sv
module uwp_fifo import uwp_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int IN_N  = 4,
  parameter int OUT_N = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 pushN,
  input  logic [IN_N-1:0][W-1:0]     pushData,
  input  logic [2:0]                 popN,
  output logic [OUT_N-1:0][W-1:0]    head,
  output logic [CNT_W-1:0]           count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] freeN, pushReq, popReq, accN;

  assign freeN   = CNT_W'(DEPTH) - count;
  assign pushReq = CNT_W'(pushN);
  assign popReq  = CNT_W'(popN);
  assign accN    = (pushReq > freeN) ? freeN : pushReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= rdPtr + PTR_W'(popReq);
      wrPtr <= wrPtr + PTR_W'(accN);
      count <= count + accN - popReq;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_N; i++) begin
      if (CNT_W'(i) < accN) mem[wrPtr + PTR_W'(i)] <= pushData[i];
    end
  end

  always_comb begin
    for (int i = 0; i < OUT_N; i++) head[i] = mem[rdPtr + PTR_W'(i)];
  end

  // R7: control never requests more pops than entries held
  a_r7_pop_bounded: assert property (@(posedge clk) disable iff (!rstN)
    popReq <= count);
  // R8: level never passes the depth
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uwp_ctrl.sv
module uwp_ctrl import uwp_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 4,
  parameter int CH_W   = 3,
  parameter int AW     = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic [AW-1:0]                 busAddr,
  input  logic [LANES-1:0]              busByteEn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  rxCount,
  output logic [CH_W-1:0]               chSel,
  output strobe_t                       strb
);
  logic [9:0]       offset;
  logic [CNT_W-1:0] avail, taken;
  logic [LANES-1:0] want;

  assign offset = busAddr[9:0];
  assign chSel  = busAddr[AW-1:10];
  assign avail  = rxCount[chSel];

  always_comb begin
    strb     = '0;
    strb.win = WIN_NONE;
    if (busValid) begin
      if (offset == OFF_BULK)                  strb.win = busWrite ? WIN_TXBULK : WIN_RXBULK;
      else if (offset == OFF_STAT && !busWrite) strb.win = WIN_RXSTAT;
    end
    case (strb.win)
      WIN_RXBULK, WIN_TXBULK: want = busByteEn;
      WIN_RXSTAT: want = {2'b00, busByteEn[3] & busByteEn[2], busByteEn[1] & busByteEn[0]};
      default:    want = '0;
    endcase
    taken = '0;
    for (int i = 0; i < LANES; i++) begin
      if (want[i] && (strb.win == WIN_TXBULK || taken < avail)) begin
        strb.slotMask[i] = 1'b1;
        taken = taken + 1'b1;
      end
    end
    if (strb.win == WIN_TXBULK) strb.pushN = 3'(taken);
    else                        strb.popN  = 3'(taken);
  end

  // R1: an access is either a read or a write, never both
  a_r1_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.popN != 3'd0, strb.pushN != 3'd0}));
  // R10: no bus access, no FIFO movement
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (strb.popN == 3'd0 && strb.pushN == 3'd0));
endmodule

// File: rtl/uwp_datapath.sv
module uwp_datapath import uwp_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int CH_W   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CH_W-1:0]               chSel,
  input  strobe_t                       strb,
  input  logic [31:0]                   busWdata,
  input  logic                          rxLoadValid,
  input  logic [CH_W-1:0]               rxLoadCh,
  input  logic [7:0]                    rxLoadData,
  input  logic [7:0]                    rxLoadStatus,
  input  logic [CH_W-1:0]               txPeekCh,
  input  logic                          txTake,
  output logic [NUM_CH-1:0][CNT_W-1:0]  rxCount,
  output logic [31:0]                   busRdata,
  output logic [7:0]                    txPeekData,
  output logic [CNT_W-1:0]              txPeekCount,
  output logic [NUM_CH-1:0]             txOverflow
);
  logic [NUM_CH-1:0][LANES-1:0][15:0] rxHead;
  logic [NUM_CH-1:0][7:0]             txHead;
  logic [NUM_CH-1:0][CNT_W-1:0]       txCount;
  logic [NUM_CH-1:0]                  ovfSet;
  logic [LANES-1:0][7:0]              txBytes;
  logic [0:0][15:0]                   rxLoadWord;
  logic [31:0]                        rdNext;
  logic                               isRxRead;

  assign rxLoadWord[0] = {rxLoadStatus, rxLoadData};
  assign isRxRead = (strb.win == WIN_RXBULK) || (strb.win == WIN_RXSTAT);

  // Gather enabled write lanes, lowest lane first
  always_comb begin
    logic [1:0] idx;
    idx = '0;
    txBytes = '0;
    for (int l = 0; l < LANES; l++) begin
      if (strb.slotMask[l]) begin
        txBytes[idx] = busWdata[8*l +: 8];
        idx = idx + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0]       rxPop, rxPush, txPush, txPop;
    logic [CNT_W-1:0] txFree;
    assign rxPop  = (isRxRead && chSel == CH_W'(c)) ? strb.popN : 3'd0;
    assign rxPush = (rxLoadValid && rxLoadCh == CH_W'(c)) ? 3'd1 : 3'd0;
    assign txPush = (strb.win == WIN_TXBULK && chSel == CH_W'(c)) ? strb.pushN : 3'd0;
    assign txPop  = (txTake && txPeekCh == CH_W'(c) && txCount[c] != '0) ? 3'd1 : 3'd0;
    assign txFree = CNT_W'(DEPTH) - txCount[c];
    assign ovfSet[c] = CNT_W'(txPush) > txFree;

    uwp_fifo #(.W(16), .DEPTH(DEPTH), .IN_N(1), .OUT_N(LANES), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rstN(rstN), .pushN(rxPush), .pushData(rxLoadWord),
      .popN(rxPop), .head(rxHead[c]), .count(rxCount[c]));

    uwp_fifo #(.W(8), .DEPTH(DEPTH), .IN_N(LANES), .OUT_N(1), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rstN(rstN), .pushN(txPush), .pushData(txBytes),
      .popN(txPop), .head(txHead[c]), .count(txCount[c]));

    // R8: overflow flag never clears once set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
      txOverflow[c] |=> txOverflow[c]);
  end

  // Pack popped entries into enabled lanes / pairs, lowest first
  always_comb begin
    logic [1:0] idx;
    idx = '0;
    rdNext = '0;
    if (strb.win == WIN_RXBULK) begin
      for (int s = 0; s < LANES; s++) begin
        if (strb.slotMask[s]) begin
          rdNext[8*s +: 8] = rxHead[chSel][idx][7:0];
          idx = idx + 1'b1;
        end
      end
    end else if (strb.win == WIN_RXSTAT) begin
      for (int p = 0; p < 2; p++) begin
        if (strb.slotMask[p]) begin
          rdNext[16*p +: 16] = {rxHead[chSel][idx][7:0], rxHead[chSel][idx][15:8]};
          idx = idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata   <= '0;
      txOverflow <= '0;
    end else begin
      busRdata   <= rdNext;
      txOverflow <= txOverflow | ovfSet;
    end
  end

  assign txPeekCount = txCount[txPeekCh];
  assign txPeekData  = (txCount[txPeekCh] != '0) ? txHead[txPeekCh] : 8'h00;

  // R9: a cycle without an RX read leaves zero on the read bus
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isRxRead |=> busRdata == 32'h0);
endmodule

// File: rtl/uart_wide_port.sv
module uart_wide_port import uwp_pkg::*; #(
  parameter  int NUM_CH = 8,
  parameter  int DEPTH  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int AW     = CH_W + 10,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [AW-1:0]     busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxLoadValid,
  input  logic [CH_W-1:0]   rxLoadCh,
  input  logic [7:0]        rxLoadData,
  input  logic [7:0]        rxLoadStatus,
  input  logic [CH_W-1:0]   txPeekCh,
  input  logic              txTake,
  output logic [7:0]        txPeekData,
  output logic [CNT_W-1:0]  txPeekCount,
  output logic [NUM_CH-1:0] txOverflow
);
  logic [NUM_CH-1:0][CNT_W-1:0] rxCount;
  logic [CH_W-1:0]              chSel;
  strobe_t                      strb;

  uwp_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .rxCount(rxCount),
    .chSel(chSel), .strb(strb));

  uwp_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .chSel(chSel), .strb(strb), .busWdata(busWdata),
    .rxLoadValid(rxLoadValid), .rxLoadCh(rxLoadCh), .rxLoadData(rxLoadData),
    .rxLoadStatus(rxLoadStatus), .txPeekCh(txPeekCh), .txTake(txTake),
    .rxCount(rxCount), .busRdata(busRdata), .txPeekData(txPeekData),
    .txPeekCount(txPeekCount), .txOverflow(txOverflow));
endmodule

// File: tb/sim_uart_wide_port.sv
module sim_uart_wide_port;
  localparam int NCH = 8;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [12:0] busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxLoadValid = 1'b0;
  logic [2:0]  rxLoadCh = '0;
  logic [7:0]  rxLoadData = '0, rxLoadStatus = '0;
  logic [2:0]  txPeekCh = '0;
  logic        txTake = 1'b0;
  logic [7:0]  txPeekData;
  logic [3:0]  txPeekCount;
  logic [7:0]  txOverflow;

  int total = 0;
  int bad = 0;

  logic [15:0] rxq [NCH][$];
  logic [7:0]  txq [NCH][$];
  logic [7:0]  ovf = '0;
  logic [31:0] expRd = '0;

  always #5ns clk = ~clk;

  uart_wide_port u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxLoadValid(rxLoadValid), .rxLoadCh(rxLoadCh), .rxLoadData(rxLoadData),
    .rxLoadStatus(rxLoadStatus), .txPeekCh(txPeekCh), .txTake(txTake),
    .txPeekData(txPeekData), .txPeekCount(txPeekCount), .txOverflow(txOverflow));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one clock edge, using the inputs currently driven
  task automatic modelEdge();
    int ch, off, k, freeN;
    logic [31:0] e;
    logic [7:0] wb[$];
    bit takeDo, loadDo;
    e = '0;
    ch = int'(busAddr[12:10]);
    off = int'(busAddr[9:0]);
    takeDo = txTake && txq[txPeekCh].size() > 0;
    loadDo = rxLoadValid && rxq[rxLoadCh].size() < DEPTH;
    k = 0;
    if (busValid && !busWrite && off == 'h100) begin
      for (int l = 0; l < 4; l++)
        if (busByteEn[l] && k < rxq[ch].size()) begin
          e[8*l +: 8] = rxq[ch][k][7:0];
          k++;
        end
    end else if (busValid && !busWrite && off == 'h200) begin
      for (int p = 0; p < 2; p++)
        if (busByteEn[2*p] && busByteEn[2*p+1] && k < rxq[ch].size()) begin
          e[16*p +: 8] = rxq[ch][k][15:8];
          e[16*p+8 +: 8] = rxq[ch][k][7:0];
          k++;
        end
    end
    for (int i = 0; i < k; i++) void'(rxq[ch].pop_front());
    if (loadDo) rxq[rxLoadCh].push_back({rxLoadStatus, rxLoadData});
    freeN = DEPTH - txq[ch].size();
    if (takeDo) void'(txq[txPeekCh].pop_front());
    if (busValid && busWrite && off == 'h100) begin
      for (int l = 0; l < 4; l++) if (busByteEn[l]) wb.push_back(busWdata[8*l +: 8]);
      if (wb.size() > freeN) ovf[ch] = 1'b1;
      for (int i = 0; i < wb.size() && i < freeN; i++) txq[ch].push_back(wb[i]);
    end
    expRd = e;
  endtask

  task automatic step(input string tag);
    logic [7:0] ePeek;
    modelEdge();
    @(posedge clk);
    #1ns;
    ePeek = (txq[txPeekCh].size() > 0) ? txq[txPeekCh][0] : 8'h00;
    chk(busRdata == expRd, tag, "busRdata", busRdata, expRd);
    chk(txPeekCount == 4'(txq[txPeekCh].size()), tag, "txPeekCount",
        32'(txPeekCount), 32'(txq[txPeekCh].size()));
    chk(txPeekData == ePeek, tag, "txPeekData", 32'(txPeekData), 32'(ePeek));
    chk(txOverflow == ovf, tag, "txOverflow", 32'(txOverflow), 32'(ovf));
  endtask

  task automatic idleAll();
    busValid = 1'b0; busWrite = 1'b0; rxLoadValid = 1'b0; txTake = 1'b0;
  endtask

  task automatic loadRx(input int ch, input logic [7:0] d, input logic [7:0] s, input string tag);
    idleAll();
    rxLoadValid = 1'b1; rxLoadCh = 3'(ch); rxLoadData = d; rxLoadStatus = s;
    step(tag);
    rxLoadValid = 1'b0;
  endtask

  task automatic access(input bit wr, input int ch, input logic [9:0] off,
                        input logic [3:0] be, input logic [31:0] wd, input string tag);
    idleAll();
    busValid = 1'b1; busWrite = wr; busAddr = {3'(ch), off}; busByteEn = be; busWdata = wd;
    step(tag);
    busValid = 1'b0;
  endtask

  task automatic take(input int ch, input string tag);
    idleAll();
    txPeekCh = 3'(ch); txTake = 1'b1;
    step(tag);
    txTake = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1ns;
    chk(busRdata == 32'h0, "R9", "reset rdata", busRdata, 32'h0);
    chk(txOverflow == 8'h0, "R8", "reset overflow", 32'(txOverflow), 32'h0);
    chk(txPeekCount == 4'h0, "R11", "reset tx level", 32'(txPeekCount), 32'h0);
    rstN = 1'b1;
    step("R9");

    // R2 / R7: bulk reads on channel 2
    loadRx(2, 8'h11, 8'h01, "R11"); loadRx(2, 8'h22, 8'h01, "R11");
    loadRx(2, 8'h33, 8'h01, "R11"); loadRx(2, 8'h44, 8'h01, "R11");
    loadRx(2, 8'h55, 8'h01, "R11"); loadRx(2, 8'h66, 8'h01, "R11");
    access(0, 2, 10'h100, 4'hF, 0, "R2");
    chk(busRdata == 32'h44332211, "R2", "bulk order", busRdata, 32'h44332211);
    access(0, 2, 10'h100, 4'hF, 0, "R7");
    chk(busRdata == 32'h00006655, "R7", "short read", busRdata, 32'h00006655);
    idleAll(); step("R9");
    chk(busRdata == 32'h0, "R9", "idle after read", busRdata, 32'h0);

    // R3 / R4: status window on channel 5
    loadRx(5, 8'hA1, 8'h01, "R11"); loadRx(5, 8'hB2, 8'h03, "R11");
    loadRx(5, 8'hC3, 8'h11, "R11");
    access(0, 5, 10'h200, 4'hF, 0, "R3");
    chk(busRdata == 32'hB203A101, "R3", "status pairs", busRdata, 32'hB203A101);
    access(0, 5, 10'h200, 4'b0011, 0, "R4");
    chk(busRdata == 32'h0000C311, "R4", "16-bit status", busRdata, 32'h0000C311);
    access(0, 5, 10'h200, 4'b0011, 0, "R7");
    chk(busRdata == 32'h0, "R7", "empty status", busRdata, 32'h0);

    // R6: partial byte enables on channel 0
    loadRx(0, 8'h10, 8'h01, "R11"); loadRx(0, 8'h20, 8'h01, "R11");
    loadRx(0, 8'h30, 8'h01, "R11"); loadRx(0, 8'h40, 8'h09, "R11");
    access(0, 0, 10'h100, 4'b1010, 0, "R6");
    chk(busRdata == 32'h20001000, "R6", "sparse lanes", busRdata, 32'h20001000);
    access(0, 0, 10'h200, 4'b1100, 0, "R6");
    chk(busRdata == 32'h30010000, "R6", "upper pair", busRdata, 32'h30010000);
    access(0, 0, 10'h200, 4'b0110, 0, "R6");
    chk(busRdata == 32'h0, "R6", "split pair", busRdata, 32'h0);
    access(0, 0, 10'h100, 4'hF, 0, "R6");
    chk(busRdata == 32'h00000040, "R6", "left after split", busRdata, 32'h00000040);

    // R5 / R1: transmit window on channel 7 (0x1D00)
    access(1, 7, 10'h100, 4'hF, 32'hD4C3B2A1, "R5");
    txPeekCh = 3'd7; step("R5");
    chk(txPeekCount == 4'd4 && txPeekData == 8'hA1, "R1", "ch7 push", 32'(txPeekData), 32'hA1);
    take(7, "R5"); chk(txPeekData == 8'hB2, "R5", "second byte", 32'(txPeekData), 32'hB2);
    take(7, "R5"); chk(txPeekData == 8'hC3, "R5", "third byte", 32'(txPeekData), 32'hC3);
    take(7, "R5"); chk(txPeekData == 8'hD4, "R5", "fourth byte", 32'(txPeekData), 32'hD4);
    take(7, "R11");
    access(1, 7, 10'h100, 4'b0101, 32'h55667788, "R6");
    chk(txPeekData == 8'h88 && txPeekCount == 4'd2, "R6", "sparse write", 32'(txPeekData), 32'h88);
    take(7, "R6"); chk(txPeekData == 8'h66, "R6", "sparse second", 32'(txPeekData), 32'h66);
    take(7, "R11"); take(7, "R11");

    // R8: overflow on channel 3
    txPeekCh = 3'd3;
    access(1, 3, 10'h100, 4'hF, 32'h04030201, "R8");
    access(1, 3, 10'h100, 4'hF, 32'h08070605, "R8");
    chk(txOverflow == 8'h00, "R8", "full not overflow", 32'(txOverflow), 32'h0);
    access(1, 3, 10'h100, 4'hF, 32'h0C0B0A09, "R8");
    chk(txOverflow == 8'h08 && txPeekCount == 4'd8, "R8", "overflow flag", 32'(txOverflow), 32'h08);
    take(3, "R8");
    chk(txOverflow == 8'h08, "R8", "flag sticky", 32'(txOverflow), 32'h08);

    // R10: other offsets have no effect
    loadRx(1, 8'h77, 8'h01, "R11");
    access(0, 1, 10'h104, 4'hF, 0, "R10");
    chk(busRdata == 32'h0, "R10", "offset 0x104", busRdata, 32'h0);
    access(0, 1, 10'h000, 4'hF, 0, "R10");
    txPeekCh = 3'd1;
    access(1, 1, 10'h200, 4'hF, 32'hFFFFFFFF, "R10");
    access(1, 1, 10'h300, 4'hF, 32'hFFFFFFFF, "R10");
    chk(txPeekCount == 4'd0, "R10", "no tx push", 32'(txPeekCount), 32'h0);
    access(0, 1, 10'h100, 4'hF, 0, "R10");
    chk(busRdata == 32'h00000077, "R10", "rx untouched", busRdata, 32'h77);

    // R1 / R11: mixed traffic, model compared every clock
    for (int i = 0; i < 600; i++) begin
      int pick;
      pick = $urandom_range(0, 3);
      busValid = 1'($urandom_range(0, 1));
      busWrite = 1'($urandom_range(0, 1));
      busAddr = {3'($urandom_range(0, 7)),
                 (pick == 0) ? 10'h100 : (pick == 1) ? 10'h200 : (pick == 2) ? 10'h104 : 10'h100};
      busByteEn = 4'($urandom_range(0, 15));
      busWdata = $urandom;
      rxLoadValid = 1'($urandom_range(0, 1));
      rxLoadCh = 3'($urandom_range(0, 7));
      rxLoadData = 8'($urandom);
      rxLoadStatus = 8'($urandom_range(0, 31));
      txPeekCh = 3'($urandom_range(0, 7));
      txTake = 1'($urandom_range(0, 1));
      step("R1 R11");
    end
    idleAll();
    step("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule